// File: doc/BRIEF.md
# Command Ring Pointer and Writeback Controller

This block keeps the state of one circular command ring that lives in memory: where the ring starts, how large it is, and how far the producer and the consumer have got. Software programs the ring through a small register port. It sets a control word, a 256-byte aligned base address, the producer pointer and a writeback target. A downstream packet decoder sees a fetch request and a fetch address. Each time it accepts a word it pulses an advance strobe, and the controller moves the consumer pointer on by one dword, wrapping at the ring size.

Pointers are exchanged in byte units but kept internally as dword indices, masked to the ring size. The ring size is given as a power of two. When writeback is enabled, the controller reports the consumer pointer to memory through a single write port. It does so once the consumer pointer has moved and either a programmable power-of-two interval has passed since the previous report or the ring has drained. A soft reset returns the engine to its initial state and keeps the address registers, so that software can zero both pointers and enable the ring again.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: After reset all pointers and the control word read zero, `idle` is 1, and neither `fetch_req` nor `wb_valid` is asserted.
- R2: Register offsets on `reg_addr` are: 0 control, 1 base, 2 read pointer, 3 write pointer, 4 writeback address low, 5 writeback address high, 6 status, 7 reads zero. In the control word, bit 0 enables the ring, bits 5:1 hold log2 of the ring size in dwords, bit 12 enables writeback and bits 20:16 hold log2 of the writeback interval in cycles. All other control bits read 0, and `ring_en` follows bit 0.
- R3: A write to the read-pointer or write-pointer register takes byte value bits [PTR_W+1:2], masked to the current ring size. A read returns the dword index shifted left by 2.
- R4: `fetch_req` is 1 exactly when the ring is enabled and the read pointer differs from the write pointer. `fetch_addr` equals base×256 plus read pointer×4.
- R5: `fetch_adv` while `fetch_req` is 1 moves the read pointer on by one dword, modulo the ring size. `fetch_adv` while `fetch_req` is 0 leaves the read pointer unchanged.
- R6: The base register holds address bits above bit 7. The writeback low register keeps bits 31:2 and reads 0 in bits 1:0. The high register keeps 8 bits, and `wb_addr` is {high, low}.
- R7: Status bit 0 and the `idle` output are 1 when the ring is disabled or the read pointer equals the write pointer.
- R8: With writeback enabled and the read pointer advanced since the last report, `wb_valid` pulses for one cycle once the cycle counter has reached 2^interval, or at once if the ring is idle. `wb_data` carries the read pointer in bytes, and the counter restarts on each report.
- R9: While control bit 12 is 0, `wb_valid` stays 0 whatever the pointers do.
- R10: `soft_rst` clears the control word, both pointers, the interval counter and any pending report. It keeps the base and writeback address registers.
- R11: A register write to the read pointer in the same cycle as an accepted advance takes precedence over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous engine reset; keeps the address registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset in dwords |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ring_en | output | 1 | Ring enable gate |
| idle | output | 1 | Ring disabled or drained |
| fetch_req | output | 1 | A word is available to fetch |
| fetch_addr | output | ADDR_W | Byte address of the next word |
| fetch_adv | input | 1 | Decoder consumed the word at `fetch_addr` |
| wb_valid | output | 1 | Writeback memory write strobe |
| wb_addr | output | ADDR_W | Writeback byte address |
| wb_data | output | 32 | Read pointer in bytes |

## Verification
The pointer assertions assume that software changes the ring size only while the ring is disabled. This is because pointers are masked at the moment they are written or advanced, not when they are compared. The bench programs the size before loading any pointer. It also assumes no register write lands in a cycle where `soft_rst` is high, and the bench keeps those two apart. `fetch_adv` is allowed to be high at any time, so the stimulus drives it randomly and also while the ring is disabled.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_BASE = 3'd1,
        RA_RPTR = 3'd2,
        RA_WPTR = 3'd3,
        RA_WBLO = 3'd4,
        RA_WBHI = 3'd5,
        RA_STAT = 3'd6,
        RA_NONE = 3'd7
    } reg_addr_e;

    // control word layout, bit 31 down to bit 0
    typedef struct packed {
        logic [10:0] rsv_top;
        logic [4:0]  tmr_log2;
        logic [2:0]  rsv_mid;
        logic        wb_on;
        logic [5:0]  rsv_low;
        logic [4:0]  size_log2;
        logic        run;
    } ctrl_t;

    localparam logic [31:0] CTRL_KEEP = 32'h001F_103F;

    function automatic logic [4:0] clamp5(input logic [4:0] v, input int lim);
        return (int'(v) > lim) ? 5'(lim) : v;
    endfunction

endpackage

// File: rtl/ring_regs.sv
module ring_regs
    import ring_pkg::*;
#(
    parameter int PTR_W  = 14,
    parameter int HI_W   = 8,
    localparam int ADDR_W = 32 + HI_W,
    localparam int BASE_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [PTR_W-1:0]  rptr,
    input  logic              idle,
    output logic [31:0]       reg_rdata,
    output logic              run,
    output logic              wb_on,
    output logic [4:0]        tmr_log2,
    output logic [PTR_W-1:0]  ptr_mask,
    output logic [PTR_W-1:0]  wptr,
    output logic [BASE_W-1:0] base,
    output logic [ADDR_W-1:0] wb_addr
);

    ctrl_t             ctrl_q;
    logic [PTR_W-1:0]  wptr_q;
    logic [BASE_W-1:0] base_q;
    logic [31:2]       wblo_q;
    logic [HI_W-1:0]   wbhi_q;
    reg_addr_e         ra;

    assign ra = reg_addr_e'(reg_addr);

    // one mask bit per pointer bit: set while below the programmed size
    for (genvar i = 0; i < PTR_W; i++) begin : g_mask
        assign ptr_mask[i] = (int'(ctrl_q.size_log2) > i);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q <= '0;
            wptr_q <= '0;
        end else if (reg_wr) begin
            if (ra == RA_CTRL) ctrl_q <= ctrl_t'(reg_wdata & CTRL_KEEP);
            if (ra == RA_WPTR) wptr_q <= reg_wdata[PTR_W+1:2] & ptr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            wblo_q <= '0;
            wbhi_q <= '0;
        end else if (reg_wr) begin
            case (ra)
                RA_BASE: base_q <= reg_wdata[BASE_W-1:0];
                RA_WBLO: wblo_q <= reg_wdata[31:2];
                RA_WBHI: wbhi_q <= reg_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (ra)
            RA_CTRL: reg_rdata = ctrl_q;
            RA_BASE: reg_rdata = 32'(base_q);
            RA_RPTR: reg_rdata = 32'({rptr, 2'b00});
            RA_WPTR: reg_rdata = 32'({wptr_q, 2'b00});
            RA_WBLO: reg_rdata = {wblo_q, 2'b00};
            RA_WBHI: reg_rdata = 32'(wbhi_q);
            RA_STAT: reg_rdata = {31'd0, idle};
            default: reg_rdata = '0;
        endcase
    end

    assign run      = ctrl_q.run;
    assign wb_on    = ctrl_q.wb_on;
    assign tmr_log2 = ctrl_q.tmr_log2;
    assign wptr     = wptr_q;
    assign base     = base_q;
    assign wb_addr  = {wbhi_q, wblo_q, 2'b00};

    p_srst_clears_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl_q == '0) && (wptr_q == '0));

    p_addr_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !reg_wr) |=> $stable(base_q) && $stable(wbhi_q));

endmodule

// File: rtl/ring_rptr.sv
module ring_rptr #(
    parameter int PTR_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             run,
    input  logic [PTR_W-1:0] ptr_mask,
    input  logic [PTR_W-1:0] wptr,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             fetch_adv,
    output logic [PTR_W-1:0] rptr,
    output logic             fetch_req,
    output logic             idle,
    output logic             moved
);

    logic [PTR_W-1:0] rptr_q;

    assign fetch_req = run && (rptr_q != wptr);
    assign idle      = !fetch_req;
    assign moved     = fetch_adv && fetch_req && !load;
    assign rptr      = rptr_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            rptr_q <= '0;
        else if (load)
            rptr_q <= load_val;
        else if (moved)
            rptr_q <= (rptr_q + 1'b1) & ptr_mask;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (!load && !(fetch_adv && fetch_req)) |=> (rptr_q == $past(rptr_q)));

    p_step_r5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (fetch_adv && fetch_req && !load) |=>
            (rptr_q == (($past(rptr_q) + 1'b1) & $past(ptr_mask))));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (rst || soft_rst)
        load |=> (rptr_q == $past(load_val)));

endmodule

// File: rtl/ring_wb.sv
module ring_wb
    import ring_pkg::*;
#(
    parameter int PTR_W = 14,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             wb_on,
    input  logic [4:0]       tmr_log2,
    input  logic             moved,
    input  logic             idle,
    input  logic [PTR_W-1:0] rptr,
    output logic             wb_valid,
    output logic [31:0]      wb_data
);

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [4:0]       tl_eff;
    logic [CNT_W-1:0] span;
    logic             fire;

    assign tl_eff = clamp5(tmr_log2, CNT_W - 1);
    assign span   = CNT_W'(1) << tl_eff;
    assign fire   = wb_on && pend_q && ((cnt_q >= span) || idle);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt_q    <= '0;
            pend_q   <= 1'b0;
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= fire;
            if (fire) wb_data <= 32'({rptr, 2'b00});
            if (fire)
                cnt_q <= '0;
            else if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
            if (moved)
                pend_q <= 1'b1;
            else if (fire)
                pend_q <= 1'b0;
        end
    end

    p_wb_gated_r9: assert property (@(posedge clk) disable iff (rst || soft_rst)
        wb_valid |-> $past(wb_on));

    p_wb_after_move_r8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        wb_valid |-> $past(pend_q));

    p_wb_restart_r8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        wb_valid |-> (cnt_q == '0));

endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
    import ring_pkg::*;
#(
    parameter int PTR_W  = 14,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 8,
    localparam int ADDR_W = 32 + HI_W,
    localparam int BASE_W = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ring_en,
    output logic              idle,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_adv,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_data
);

    logic              run, wb_on, moved, load;
    logic [4:0]        tmr_log2;
    logic [PTR_W-1:0]  ptr_mask, wptr, rptr, load_val;
    logic [BASE_W-1:0] base;

    assign load     = reg_wr && (reg_addr_e'(reg_addr) == RA_RPTR);
    assign load_val = reg_wdata[PTR_W+1:2] & ptr_mask;

    ring_regs #(.PTR_W(PTR_W), .HI_W(HI_W)) u_regs (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rptr(rptr), .idle(idle), .reg_rdata(reg_rdata),
        .run(run), .wb_on(wb_on), .tmr_log2(tmr_log2),
        .ptr_mask(ptr_mask), .wptr(wptr), .base(base), .wb_addr(wb_addr)
    );

    ring_rptr #(.PTR_W(PTR_W)) u_rptr (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .run(run), .ptr_mask(ptr_mask), .wptr(wptr),
        .load(load), .load_val(load_val), .fetch_adv(fetch_adv),
        .rptr(rptr), .fetch_req(fetch_req), .idle(idle), .moved(moved)
    );

    ring_wb #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_wb (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .wb_on(wb_on), .tmr_log2(tmr_log2), .moved(moved), .idle(idle),
        .rptr(rptr), .wb_valid(wb_valid), .wb_data(wb_data)
    );

    assign ring_en    = run;
    assign fetch_addr = {base, 8'h00} + ADDR_W'({rptr, 2'b00});

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> ring_en);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!fetch_req && !wb_valid && idle));

endmodule

// File: tb/ring_ptr_ctrl_bench.sv
module ring_ptr_ctrl_bench;

    localparam int CLK_T  = 10;
    localparam int PTR_W  = 14;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_rst = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              fetch_adv = 1'b0;
    logic [31:0]       reg_rdata, wb_data;
    logic              ring_en, idle, fetch_req, wb_valid;
    logic [ADDR_W-1:0] fetch_addr, wb_addr;

    ring_ptr_ctrl u_ring_ptr_ctrl (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ring_en(ring_en), .idle(idle),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_adv(fetch_adv),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #(CLK_T/2) clk = ~clk;

    int checks = 0, errors = 0, wb_seen = 0;
    bit done = 1'b0;

    // behavioural reference state
    longint m_ctrl, m_base, m_rp, m_wp, m_wblo, m_wbhi, m_cnt, m_wbd;
    bit     m_dirty, m_wbv;

    function automatic longint m_mask();
        longint sz = (m_ctrl >> 1) & 31;
        if (sz > PTR_W) sz = PTR_W;
        return (longint'(1) << sz) - 1;
    endfunction

    function automatic bit m_req();
        return ((m_ctrl & 1) != 0) && (m_rp != m_wp);
    endfunction

    function automatic longint m_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_base;
            3'd2: return m_rp * 4;
            3'd3: return m_wp * 4;
            3'd4: return m_wblo;
            3'd5: return m_wbhi;
            3'd6: return longint'(!m_req());
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2 control readback";
            3'd2, 3'd3: return "R3 pointer readback";
            3'd6: return "R7 status readback";
            default: return "R6 address readback";
        endcase
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_base = 0; m_rp = 0; m_wp = 0; m_wblo = 0; m_wbhi = 0;
            m_cnt = 0; m_wbd = 0; m_dirty = 0; m_wbv = 0;
        end else if (soft_rst) begin
            m_ctrl = 0; m_rp = 0; m_wp = 0; m_cnt = 0; m_dirty = 0; m_wbv = 0;
        end else begin
            longint mask, tl;
            bit req, fire, ld, adv;
            mask = m_mask();
            req  = m_req();
            tl   = (m_ctrl >> 16) & 31;
            if (tl > CNT_W - 1) tl = CNT_W - 1;
            fire = (((m_ctrl >> 12) & 1) != 0) && m_dirty &&
                   ((m_cnt >= (longint'(1) << tl)) || !req);
            ld   = reg_wr && (reg_addr == 3'd2);
            adv  = fetch_adv && req && !ld;
            m_wbv = fire;
            if (fire) m_wbd = m_rp * 4;
            if (fire) m_cnt = 0;
            else if (m_cnt < (longint'(1) << CNT_W) - 1) m_cnt++;
            if (adv) m_dirty = 1;
            else if (fire) m_dirty = 0;
            if (ld) m_rp = (longint'(reg_wdata) >> 2) & mask;
            else if (adv) m_rp = (m_rp + 1) & mask;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_ctrl = longint'(reg_wdata) & 'h1F103F;
                    3'd1: m_base = longint'(reg_wdata);
                    3'd3: m_wp   = (longint'(reg_wdata) >> 2) & mask;
                    3'd4: m_wblo = longint'(reg_wdata) & 'hFFFFFFFC;
                    3'd5: m_wbhi = longint'(reg_wdata) & 'hFF;
                    default: ;
                endcase
            end
        end
    end

    // compare against the reference on every clock, half a period after the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 fetch_req", longint'(fetch_req), longint'(m_req()));
            chk("R4 fetch_addr", longint'(fetch_addr),
                ((m_base << 8) + m_rp * 4) & ((longint'(1) << ADDR_W) - 1));
            chk("R7 idle", longint'(idle), longint'(!m_req()));
            chk("R2 ring_en", longint'(ring_en), m_ctrl & 1);
            chk("R8 wb_valid", longint'(wb_valid), longint'(m_wbv));
            if (m_wbv) begin
                chk("R8 wb_data", longint'(wb_data), m_wbd);
                chk("R6 wb_addr", longint'(wb_addr), (m_wbhi << 32) | m_wblo);
            end
            chk(rd_tag(reg_addr), longint'(reg_rdata), m_rdata(reg_addr));
            if (wb_valid === 1'b1) wb_seen++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input longint exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        #1;
        chk(tag, longint'(reg_rdata), exp);
        tick();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 got running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        rd(3'd2, 0, "R1 read pointer after reset");
        rd(3'd0, 0, "R1 control after reset");
        rd(3'd6, 1, "R1 status idle after reset");
        chk("R1 no fetch after reset", longint'(fetch_req), 0);
        chk("R1 no writeback after reset", longint'(wb_valid), 0);
        // R2: only defined control bits stick
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 'h001F103F, "R2 control mask");
        wr(3'd0, 32'h0000_0008);
        // R6: address registers
        wr(3'd1, 32'h0001_2345);
        wr(3'd4, 32'hABCD_0007);
        wr(3'd5, 32'h0000_01FF);
        rd(3'd4, 'hABCD0004, "R6 writeback low bits forced zero");
        rd(3'd5, 'hFF, "R6 writeback high width");
        rd(3'd1, 'h12345, "R6 base");
        // R3: byte units and size mask (16 dwords)
        wr(3'd3, 32'h17);
        rd(3'd3, 'h14, "R3 write pointer bytes");
        wr(3'd3, 32'h4C);
        rd(3'd3, 'hC, "R3 write pointer wrap mask");
        wr(3'd3, 32'h0);
        // R8: run with writeback, interval 4
        wr(3'd0, 32'h0002_1009);
        wb_seen = 0;
        wr(3'd3, 32'd20);
        fetch_adv = 1'b1;
        repeat (10) tick();
        fetch_adv = 1'b0;
        rd(3'd2, 20, "R5 advanced to write pointer");
        chk("R8 writeback seen", longint'(wb_seen > 0), 1);
        // R5: wrap past the ring end with a random consumer
        wr(3'd3, 32'd8);
        for (int i = 0; i < 60; i++) begin
            fetch_adv = 1'($urandom % 2);
            tick();
        end
        fetch_adv = 1'b1;
        repeat (16) tick();
        fetch_adv = 1'b0;
        rd(3'd2, 8, "R5 wrap to write pointer");
        // R5: advance ignored while disabled
        wr(3'd0, 32'h0002_1008);
        wr(3'd3, 32'd40);
        fetch_adv = 1'b1;
        repeat (5) tick();
        chk("R5 no fetch while disabled", longint'(fetch_req), 0);
        fetch_adv = 1'b0;
        rd(3'd2, 8, "R5 ignored advance");
        // R11: register write beats an advance
        wr(3'd0, 32'h0002_1009);
        fetch_adv = 1'b1;
        wr(3'd2, 32'h3C);
        fetch_adv = 1'b0;
        rd(3'd2, 'h3C, "R11 write over advance");
        // R9: writeback disabled
        wr(3'd0, 32'h0000_0009);
        wb_seen = 0;
        fetch_adv = 1'b1;
        repeat (20) tick();
        fetch_adv = 1'b0;
        tick();
        chk("R9 no writeback when off", longint'(wb_seen), 0);
        // R8: long interval, random consumer
        wr(3'd0, 32'h0006_1009);
        wr(3'd3, 32'h24);
        for (int i = 0; i < 120; i++) begin
            fetch_adv = 1'(($urandom % 4) == 0);
            tick();
        end
        fetch_adv = 1'b0;
        repeat (4) tick();
        // R10: soft reset
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        rd(3'd0, 0, "R10 control cleared");
        rd(3'd2, 0, "R10 read pointer cleared");
        rd(3'd3, 0, "R10 write pointer cleared");
        rd(3'd1, 'h12345, "R10 base kept");
        rd(3'd5, 'hFF, "R10 writeback high kept");
        finish_run();
    end

endmodule